// File: doc/BRIEF.md
# Two-Wire Bus Byte FIFO Pair with Threshold and Drain Events

This block holds the transmit and receive byte queues of a two-wire serial bus controller. The host fills the transmit queue and the bus shifter empties it; the bus shifter fills the receive queue and the host empties it. Before each transfer the host loads a non-zero byte count and a direction. The block keeps a count of the bytes the host still has to move and uses it, with the queue levels and two programmable thresholds, to raise the four event flags that a status register latches.

A ready event asks the host to move a threshold-sized burst. When fewer bytes are left in the transfer than the threshold, a ready event could never come, so the block raises a drain event instead. On receive, drain means every byte still owed to the host is already queued: the host reads exactly the remaining count. Each queue can be flushed from the configuration word. A fixed code reports the queue capacity.

Top module: `twb_fifo_pair`

## Requirements
- R1: After reset both queue levels, the byte counter, the four event flags and the four sticky error flags are 0.
- R2: Each queue returns bytes in the order they were accepted; read data shows the oldest byte without a pop, and the level follows accepted pushes and pops.
- R3: A push to a full queue (level = 8 << depth code) is dropped without changing stored data or level and sets that queue's sticky overflow flag; a pop from an empty queue is dropped and sets its sticky underflow flag.
- R4: Writing the configuration word with bit 6 set empties the transmit queue, with bit 14 set empties the receive queue, and clears that queue's sticky flags by the next cycle; the other queue is untouched and the clear does not persist (a push in the following cycle is accepted).
- R5: Configuration bits [5:0] hold the transmit threshold minus one and bits [13:8] the receive threshold minus one; the effective threshold is that value plus one, limited to the queue capacity. Reset value of both fields is 0.
- R6: A byte-count load with a non-zero value sets the counter and the direction (direction input 1 = transmit, 0 = receive); a load of zero changes neither.
- R7: The counter drops by one for each accepted host push in a transmit transfer and each accepted host pop in a receive transfer, never below zero; refused moves and bus-side moves leave it unchanged.
- R8: Transmit-ready is high in a transmit transfer when the counter is at least the transmit threshold and the transmit level is below it.
- R9: Transmit-drain is high in a transmit transfer when the counter is non-zero but below the transmit threshold and the transmit level is below that threshold; it is never high together with transmit-ready.
- R10: Receive-ready is high in a receive transfer when the counter is non-zero and the receive level is at least the receive threshold.
- R11: Receive-drain is high in a receive transfer when the receive level is below the receive threshold and equals the non-zero counter.
- R12: With the counter at zero, or for the flags of the direction not in use, all event flags are low.
- R13: The depth code output equals the depth-code parameter and the queue capacity is 8 << code bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_word | input | 16 | Thresholds and flush bits |
| len_wr | input | 1 | Load strobe for the byte count |
| len_value | input | CNT_W | Transfer byte count |
| len_is_tx | input | 1 | Direction of the loaded transfer, 1 = transmit |
| host_tx_push | input | 1 | Host writes a byte to the transmit queue |
| host_tx_byte | input | 8 | Byte written by the host |
| bus_tx_pop | input | 1 | Shifter takes a byte from the transmit queue |
| bus_tx_byte | output | 8 | Oldest transmit byte |
| bus_rx_push | input | 1 | Shifter writes a byte to the receive queue |
| bus_rx_byte | input | 8 | Byte written by the shifter |
| host_rx_pop | input | 1 | Host takes a byte from the receive queue |
| host_rx_byte | output | 8 | Oldest receive byte |
| tx_level | output | LVL_W | Bytes held in the transmit queue |
| rx_level | output | LVL_W | Bytes held in the receive queue |
| bytes_left | output | CNT_W | Bytes the host still has to move |
| tx_ready | output | 1 | Transmit threshold event |
| tx_drain | output | 1 | Transmit end-of-transfer event |
| rx_ready | output | 1 | Receive threshold event |
| rx_drain | output | 1 | Receive end-of-transfer event |
| tx_overflow | output | 1 | Sticky: push to full transmit queue |
| tx_underflow | output | 1 | Sticky: pop from empty transmit queue |
| rx_overflow | output | 1 | Sticky: push to full receive queue |
| rx_underflow | output | 1 | Sticky: pop from empty receive queue |
| depth_code | output | 3 | Capacity code, capacity = 8 << code |

## Verification
The bench builds the block with depth code 0 and an 8-bit counter, so each queue holds eight bytes and fills in eight pushes, which puts overflow and the clamping of a 64-byte threshold request down to the capacity within a few cycles. Thresholds of 3 and 4 with transfers of 4 and 6 bytes walk both directions through ready, drain and silence, including the hand-over from ready to drain as the counter passes the threshold.

// File: rtl/twb_fifo_pkg.sv
package twb_fifo_pkg;

    localparam int DATA_W     = 8;
    localparam int THR_W      = 6;
    localparam int CFG_W      = 16;
    localparam int DCODE_W    = 3;

    localparam int TX_THR_LSB = 0;
    localparam int TX_CLR_BIT = 6;
    localparam int RX_THR_LSB = 8;
    localparam int RX_CLR_BIT = 14;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } twb_dir_e;

    typedef struct packed {
        logic [THR_W-1:0] rx_thr_m1;
        logic [THR_W-1:0] tx_thr_m1;
    } twb_cfg_t;

    typedef struct packed {
        logic tx_ready;
        logic tx_drain;
        logic rx_ready;
        logic rx_drain;
    } twb_evt_t;

    function automatic int depth_of(input int code);
        return 8 << code;
    endfunction

    function automatic logic [THR_W:0] eff_thr(input logic [THR_W-1:0] field,
                                              input int depth);
        logic [THR_W:0] v;
        v = {1'b0, field} + 1'b1;
        if (int'(v) > depth) v = (THR_W+1)'(depth);
        return v;
    endfunction

endpackage

// File: rtl/twb_byte_fifo.sv
module twb_byte_fifo
    import twb_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  level,
    output logic              push_acc,
    output logic              pop_acc,
    output logic              ovf,
    output logic              unf
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              full, empty;

    assign full     = (level == FULL_LVL);
    assign empty    = (level == '0);
    assign push_acc = push && !full && !flush;
    assign pop_acc  = pop && !empty && !flush;
    assign rdata    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_acc) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            if (push_acc) wptr <= wptr + 1'b1;
            if (pop_acc)  rptr <= rptr + 1'b1;
            case ({push_acc, pop_acc})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (push && full)  ovf <= 1'b1;
            if (pop && empty)  unf <= 1'b1;
        end
    end

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (level == FULL_LVL) && ovf);

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push && !flush) |=> (level == '0) && unf);

    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0) && !ovf && !unf);

endmodule

// File: rtl/twb_xfer_tracker.sv
module twb_xfer_tracker
    import twb_fifo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             len_wr,
    input  logic [CNT_W-1:0] len_value,
    input  logic             len_is_tx,
    input  logic             tx_push_acc,
    input  logic             rx_pop_acc,
    output logic [CNT_W-1:0] remaining,
    output twb_dir_e         dir
);
    logic load, step;

    assign load = len_wr && (len_value != '0);
    assign step = (dir == DIR_TX) ? tx_push_acc : rx_pop_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            dir       <= DIR_RX;
        end else if (load) begin
            remaining <= len_value;
            dir       <= len_is_tx ? DIR_TX : DIR_RX;
        end else if (step && remaining != '0) begin
            remaining <= remaining - 1'b1;
        end
    end

    assert_zero_len_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (len_wr && len_value == '0 && !step) |=>
            (remaining == $past(remaining)) && (dir == $past(dir)));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        (!len_wr) |=> (remaining == $past(remaining)) ||
                      (remaining == $past(remaining) - 1'b1));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (!len_wr && remaining == '0) |=> remaining == '0);

endmodule

// File: rtl/twb_event_gen.sv
module twb_event_gen
    import twb_fifo_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] remaining,
    input  twb_dir_e         dir,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W:0]   tx_thr,
    input  logic [THR_W:0]   rx_thr,
    output twb_evt_t         evt
);
    logic [31:0] rem32, txl32, rxl32, txt32, rxt32;
    logic        live_tx, live_rx;

    assign rem32 = 32'(remaining);
    assign txl32 = 32'(tx_level);
    assign rxl32 = 32'(rx_level);
    assign txt32 = 32'(tx_thr);
    assign rxt32 = 32'(rx_thr);

    assign live_tx = (dir == DIR_TX) && (rem32 != 0);
    assign live_rx = (dir == DIR_RX) && (rem32 != 0);

    always_comb begin
        evt          = '0;
        evt.tx_ready = live_tx && (txl32 < txt32) && (rem32 >= txt32);
        evt.tx_drain = live_tx && (txl32 < txt32) && (rem32 <  txt32);
        evt.rx_ready = live_rx && (rxl32 >= rxt32);
        evt.rx_drain = live_rx && (rxl32 <  rxt32) && (rxl32 == rem32);
    end

    assert_tx_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(evt.tx_ready && evt.tx_drain));

    assert_rx_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(evt.rx_ready && evt.rx_drain));

    assert_one_side_R12: assert property (@(posedge clk) disable iff (rst)
        $countones({evt.tx_ready | evt.tx_drain, evt.rx_ready | evt.rx_drain}) <= 1);

endmodule

// File: rtl/twb_fifo_pair.sv
module twb_fifo_pair
    import twb_fifo_pkg::*;
#(
    parameter int DEPTH_CODE = 0,
    parameter int CNT_W      = 16,
    localparam int DEPTH     = depth_of(DEPTH_CODE),
    localparam int LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              len_wr,
    input  logic [CNT_W-1:0]  len_value,
    input  logic              len_is_tx,
    input  logic              host_tx_push,
    input  logic [DATA_W-1:0] host_tx_byte,
    input  logic              bus_tx_pop,
    output logic [DATA_W-1:0] bus_tx_byte,
    input  logic              bus_rx_push,
    input  logic [DATA_W-1:0] bus_rx_byte,
    input  logic              host_rx_pop,
    output logic [DATA_W-1:0] host_rx_byte,
    output logic [LVL_W-1:0]  tx_level,
    output logic [LVL_W-1:0]  rx_level,
    output logic [CNT_W-1:0]  bytes_left,
    output logic              tx_ready,
    output logic              tx_drain,
    output logic              rx_ready,
    output logic              rx_drain,
    output logic              tx_overflow,
    output logic              tx_underflow,
    output logic              rx_overflow,
    output logic              rx_underflow,
    output logic [DCODE_W-1:0] depth_code
);
    twb_cfg_t       cfg_q;
    twb_evt_t       evt;
    twb_dir_e       dir;
    logic           tx_flush, rx_flush;
    logic           tx_push_acc, tx_pop_acc, rx_push_acc, rx_pop_acc;
    logic [THR_W:0] tx_thr, rx_thr;

    assign tx_flush   = cfg_wr && cfg_word[TX_CLR_BIT];
    assign rx_flush   = cfg_wr && cfg_word[RX_CLR_BIT];
    assign depth_code = DCODE_W'(DEPTH_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.tx_thr_m1 <= cfg_word[TX_THR_LSB +: THR_W];
            cfg_q.rx_thr_m1 <= cfg_word[RX_THR_LSB +: THR_W];
        end
    end

    assign tx_thr = eff_thr(cfg_q.tx_thr_m1, DEPTH);
    assign rx_thr = eff_thr(cfg_q.rx_thr_m1, DEPTH);

    twb_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(host_tx_push), .wdata(host_tx_byte),
        .pop(bus_tx_pop), .rdata(bus_tx_byte),
        .level(tx_level), .push_acc(tx_push_acc), .pop_acc(tx_pop_acc),
        .ovf(tx_overflow), .unf(tx_underflow)
    );

    twb_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(bus_rx_push), .wdata(bus_rx_byte),
        .pop(host_rx_pop), .rdata(host_rx_byte),
        .level(rx_level), .push_acc(rx_push_acc), .pop_acc(rx_pop_acc),
        .ovf(rx_overflow), .unf(rx_underflow)
    );

    twb_xfer_tracker #(.CNT_W(CNT_W)) u_tracker (
        .clk(clk), .rst(rst),
        .len_wr(len_wr), .len_value(len_value), .len_is_tx(len_is_tx),
        .tx_push_acc(tx_push_acc), .rx_pop_acc(rx_pop_acc),
        .remaining(bytes_left), .dir(dir)
    );

    twb_event_gen #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_events (
        .clk(clk), .rst(rst),
        .remaining(bytes_left), .dir(dir),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .evt(evt)
    );

    assign tx_ready = evt.tx_ready;
    assign tx_drain = evt.tx_drain;
    assign rx_ready = evt.rx_ready;
    assign rx_drain = evt.rx_drain;

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (bytes_left == '0) |-> !(tx_ready || tx_drain || rx_ready || rx_drain));

    assert_dir_gate_R12: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_RX) |-> !(tx_ready || tx_drain));

    assert_thr_cap_R5: assert property (@(posedge clk) disable iff (rst)
        (32'(tx_thr) <= DEPTH) && (32'(rx_thr) <= DEPTH) && tx_thr != '0 && rx_thr != '0);

    assert_rx_drain_count_R11: assert property (@(posedge clk) disable iff (rst)
        rx_drain |-> (32'(rx_level) == 32'(bytes_left)));

    assert_tx_decrement_R7: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_TX && !len_wr && host_tx_push && !tx_flush &&
         32'(tx_level) < DEPTH && bytes_left != '0)
            |=> bytes_left == $past(bytes_left) - 1'b1);

endmodule

// File: tb/twb_fifo_pair_tb.sv
`timescale 1ns/1ps
module twb_fifo_pair_tb;

    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [15:0] cfg_word;
    logic        len_wr;
    logic [CW-1:0] len_value;
    logic        len_is_tx;
    logic        host_tx_push;
    logic [7:0]  host_tx_byte;
    logic        bus_tx_pop;
    logic [7:0]  bus_tx_byte;
    logic        bus_rx_push;
    logic [7:0]  bus_rx_byte;
    logic        host_rx_pop;
    logic [7:0]  host_rx_byte;
    logic [3:0]  tx_level, rx_level;
    logic [CW-1:0] bytes_left;
    logic        tx_ready, tx_drain, rx_ready, rx_drain;
    logic        tx_overflow, tx_underflow, rx_overflow, rx_underflow;
    logic [2:0]  depth_code;

    int checks = 0;
    int bad    = 0;

    always #2.5 clk = ~clk;

    twb_fifo_pair #(.DEPTH_CODE(0), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .len_wr(len_wr), .len_value(len_value), .len_is_tx(len_is_tx),
        .host_tx_push(host_tx_push), .host_tx_byte(host_tx_byte),
        .bus_tx_pop(bus_tx_pop), .bus_tx_byte(bus_tx_byte),
        .bus_rx_push(bus_rx_push), .bus_rx_byte(bus_rx_byte),
        .host_rx_pop(host_rx_pop), .host_rx_byte(host_rx_byte),
        .tx_level(tx_level), .rx_level(rx_level), .bytes_left(bytes_left),
        .tx_ready(tx_ready), .tx_drain(tx_drain),
        .rx_ready(rx_ready), .rx_drain(rx_drain),
        .tx_overflow(tx_overflow), .tx_underflow(tx_underflow),
        .rx_overflow(rx_overflow), .rx_underflow(rx_underflow),
        .depth_code(depth_code)
    );

    // op codes of the vector table
    localparam logic [2:0] OP_CFG = 3'd1, OP_LTX = 3'd2, OP_LRX = 3'd3,
                           OP_TXW = 3'd4, OP_TXR = 3'd5, OP_RXW = 3'd6,
                           OP_RXR = 3'd7;

    // {op, arg, tx_level, rx_level, bytes_left, {txr, txd, rxr, rxd}}
    // for pop ops, arg is the byte expected at the head before the pop
    localparam int NV = 21;
    localparam logic [38:0] VEC [NV] = '{
        {OP_CFG, 16'h0203, 4'd0, 4'd0, 8'd0, 4'b0000}, // R5: tx thr 4, rx thr 3
        {OP_LTX, 16'd6,    4'd0, 4'd0, 8'd6, 4'b1000}, // R6 R8
        {OP_TXW, 16'h0011, 4'd1, 4'd0, 8'd5, 4'b1000},
        {OP_TXW, 16'h0022, 4'd2, 4'd0, 8'd4, 4'b1000},
        {OP_TXW, 16'h0033, 4'd3, 4'd0, 8'd3, 4'b0100}, // R9
        {OP_TXW, 16'h0044, 4'd4, 4'd0, 8'd2, 4'b0000},
        {OP_TXR, 16'h0011, 4'd3, 4'd0, 8'd2, 4'b0100}, // R2 R7 bus pop no count
        {OP_TXW, 16'h0055, 4'd4, 4'd0, 8'd1, 4'b0000},
        {OP_TXR, 16'h0022, 4'd3, 4'd0, 8'd1, 4'b0100},
        {OP_TXW, 16'h0066, 4'd4, 4'd0, 8'd0, 4'b0000},
        {OP_TXR, 16'h0033, 4'd3, 4'd0, 8'd0, 4'b0000}, // R12
        {OP_LTX, 16'd0,    4'd3, 4'd0, 8'd0, 4'b0000}, // R6 zero ignored
        {OP_LRX, 16'd4,    4'd3, 4'd0, 8'd4, 4'b0000}, // R12 tx side quiet
        {OP_RXW, 16'h00A1, 4'd3, 4'd1, 8'd4, 4'b0000},
        {OP_RXW, 16'h00A2, 4'd3, 4'd2, 8'd4, 4'b0000},
        {OP_RXW, 16'h00A3, 4'd3, 4'd3, 8'd4, 4'b0010}, // R10
        {OP_RXR, 16'h00A1, 4'd3, 4'd2, 8'd3, 4'b0000},
        {OP_RXW, 16'h00A4, 4'd3, 4'd3, 8'd3, 4'b0010},
        {OP_RXR, 16'h00A2, 4'd3, 4'd2, 8'd2, 4'b0001}, // R11
        {OP_RXR, 16'h00A3, 4'd3, 4'd1, 8'd1, 4'b0001},
        {OP_RXR, 16'h00A4, 4'd3, 4'd0, 8'd0, 4'b0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_cfg(input logic [15:0] w);
        cfg_wr = 1'b1; cfg_word = w; cyc(); cfg_wr = 1'b0;
    endtask

    task automatic do_len(input logic [CW-1:0] n, input logic tx);
        len_wr = 1'b1; len_value = n; len_is_tx = tx; cyc(); len_wr = 1'b0;
    endtask

    task automatic do_txw(input logic [7:0] b);
        host_tx_push = 1'b1; host_tx_byte = b; cyc(); host_tx_push = 1'b0;
    endtask

    task automatic do_txr();
        bus_tx_pop = 1'b1; cyc(); bus_tx_pop = 1'b0;
    endtask

    task automatic do_rxw(input logic [7:0] b);
        bus_rx_push = 1'b1; bus_rx_byte = b; cyc(); bus_rx_push = 1'b0;
    endtask

    task automatic do_rxr();
        host_rx_pop = 1'b1; cyc(); host_rx_pop = 1'b0;
    endtask

    function automatic logic [3:0] evts();
        return {tx_ready, tx_drain, rx_ready, rx_drain};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1 actual=hang expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 0; cfg_word = 0; len_wr = 0; len_value = 0;
        len_is_tx = 0; host_tx_push = 0; host_tx_byte = 0; bus_tx_pop = 0;
        bus_rx_push = 0; bus_rx_byte = 0; host_rx_pop = 0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state, R13 depth code
        chk("R1 tx_level", 32'(tx_level), 0);
        chk("R1 rx_level", 32'(rx_level), 0);
        chk("R1 bytes_left", 32'(bytes_left), 0);
        chk("R1 events", 32'(evts()), 0);
        chk("R1 sticky", 32'({tx_overflow, tx_underflow, rx_overflow, rx_underflow}), 0);
        chk("R13 depth_code", 32'(depth_code), 0);

        // table walk: R2 R5 R6 R7 R8 R9 R10 R11 R12
        for (int i = 0; i < NV; i++) begin
            logic [38:0] v;
            v = VEC[i];
            case (v[38:36])
                OP_CFG: do_cfg(v[35:20]);
                OP_LTX: do_len(v[20+CW-1:20], 1'b1);
                OP_LRX: do_len(v[20+CW-1:20], 1'b0);
                OP_TXW: do_txw(v[27:20]);
                OP_TXR: begin
                    chk("R2 tx head", 32'(bus_tx_byte), 32'(v[27:20]));
                    do_txr();
                end
                OP_RXW: do_rxw(v[27:20]);
                OP_RXR: begin
                    chk("R2 rx head", 32'(host_rx_byte), 32'(v[27:20]));
                    do_rxr();
                end
                default: cyc();
            endcase
            chk("R2 tx_level", 32'(tx_level), 32'(v[19:16]));
            chk("R2 rx_level", 32'(rx_level), 32'(v[15:12]));
            chk("R7 bytes_left", 32'(bytes_left), 32'(v[11:4]));
            chk("R8 R9 R10 R11 R12 events", 32'(evts()), 32'(v[3:0]));
        end

        // R4 transmit flush, thresholds back to 1
        do_cfg(16'h0040);
        chk("R4 tx flushed", 32'(tx_level), 0);

        // R3 transmit overflow at capacity 8 (R13)
        for (int i = 0; i < 9; i++) do_txw(8'h80 + 8'(i));
        chk("R3 tx full level", 32'(tx_level), 8);
        chk("R3 tx overflow", 32'(tx_overflow), 1);
        for (int i = 0; i < 8; i++) begin
            chk("R3 tx data kept", 32'(bus_tx_byte), 32'(8'h80 + 8'(i)));
            do_txr();
        end
        chk("R3 tx no underflow yet", 32'(tx_underflow), 0);
        do_txr();
        chk("R3 tx underflow", 32'(tx_underflow), 1);
        chk("R3 tx level empty", 32'(tx_level), 0);
        do_cfg(16'h0040);
        chk("R4 tx sticky cleared", 32'({tx_overflow, tx_underflow}), 0);

        // R4 receive flush leaves transmit queue alone
        do_rxw(8'hC0);
        do_rxw(8'hC1);
        do_txw(8'h99);
        do_cfg(16'h4000);
        chk("R4 rx flushed", 32'(rx_level), 0);
        chk("R4 tx untouched", 32'(tx_level), 1);
        do_rxw(8'hC2);
        chk("R4 push after flush", 32'(rx_level), 1);
        chk("R4 head after flush", 32'(host_rx_byte), 32'(8'hC2));
        do_rxr();
        do_rxr();
        chk("R3 rx underflow", 32'(rx_underflow), 1);
        for (int i = 0; i < 9; i++) do_rxw(8'(i));
        chk("R3 rx overflow", 32'(rx_overflow), 1);
        chk("R3 rx full level", 32'(rx_level), 8);
        do_cfg(16'h4040);
        chk("R4 both cleared", 32'({tx_level, rx_level, tx_overflow, tx_underflow,
                                     rx_overflow, rx_underflow}), 0);

        // R5 threshold request of 64 clamps to capacity 8
        do_cfg(16'h3F3F);
        do_len(8'd8, 1'b1);
        chk("R5 clamp gives ready", 32'(evts()), 32'(4'b1000));
        for (int i = 0; i < 7; i++) do_txw(8'(i));
        chk("R9 drain near end", 32'(evts()), 32'(4'b0100));
        chk("R7 count after 7", 32'(bytes_left), 1);
        do_txw(8'h07);
        chk("R12 quiet at zero", 32'(evts()), 0);

        // R7 refused push does not count
        do_len(8'd3, 1'b1);
        do_txw(8'hEE);
        chk("R7 refused push", 32'(bytes_left), 3);
        chk("R3 overflow on refuse", 32'(tx_overflow), 1);

        // R7 bus-side receive push does not count, host pop does
        do_len(8'd5, 1'b0);
        do_rxw(8'h5A);
        chk("R7 bus push no count", 32'(bytes_left), 5);
        chk("R11 no drain 1 of 5", 32'(evts()), 0);
        do_rxr();
        chk("R7 host pop counts", 32'(bytes_left), 4);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule